// File: doc/BRIEF.md
# Received Packet Framer for a PHY/Link Byte Interface

This block sits on the link side of a byte-wide PHY interface. It samples a 2-bit control code and an 8-bit data byte on every interface clock and turns them into framed packets. A receive begins with Receive on the control pins and an all-ones prefix on the data bus. The next byte carries the transfer rate. It is decoded with partial bit masks and is never passed on as payload.

Every later byte is streamed out with a valid strobe, with a start marker on the first one, and is flagged as CRC-eligible. The return of the control code to Idle closes the packet with an end pulse. Three other outcomes are reported as single pulses instead: a prefix that falls straight back to Idle (null receive), an unknown rate byte (speed error, with the rest of that packet discarded), and a reserved control code seen mid-receive (abort). All outputs are registered, so each one reflects the input sampled at the previous clock edge.

Top module: `rx_pkt_decoder`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a packet, every strobe and pulse output is low, the rate output is 2'b00, and the block waits for a new prefix.
- R2: Control code 2'b10 (Receive) with a data byte whose bits [7:6] are 2'b11 starts a receive, or continues its prefix phase. No output strobe or pulse fires during the prefix.
- R3: The first byte under Receive whose bits [7:6] are not 2'b11 is the rate byte. It sets the rate output one cycle later to 2'b00 when bits [7:6] are 2'b00, to 2'b01 when bits [7:4] are 4'b0100, and to 2'b10 when the byte is exactly 8'h50. The rate output then holds until the next valid rate byte.
- R4: The rate byte produces no valid strobe and no CRC flag. The first byte after it is output one cycle later with valid, start and CRC-eligible all high, and carries the input value unchanged, even when its top bits are 2'b11.
- R5: Each further byte under Receive is output with valid and CRC-eligible high and start low.
- R6: Control code 2'b00 (Idle) after the rate byte gives a one-cycle end pulse, even when no payload byte arrived.
- R7: Idle directly after the prefix gives a one-cycle null pulse, and no valid strobe and no end pulse.
- R8: A rate byte that matches none of the three patterns gives a one-cycle speed-error pulse and leaves the rate output unchanged. The bytes that follow produce no output until Idle, and that Idle produces no end pulse.
- R9: Control code 2'b01 or 2'b11 during a receive (prefix, payload or discard phase) gives a one-cycle abort pulse without an end pulse, and the block returns to waiting.
- R10: While the block waits, control codes other than Receive are ignored whatever the data byte is. A Receive whose byte is not a prefix is discarded up to the next Idle and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_ctl_i | input | 2 | Control code from the PHY: 00 Idle, 10 Receive, 01/11 reserved |
| phy_byte_i | input | 8 | Data byte from the PHY |
| rx_data_o | output | 8 | Payload byte, meaningful while rx_valid_o is high |
| rx_valid_o | output | 1 | Payload byte strobe |
| rx_start_o | output | 1 | First payload byte of a packet |
| rx_crc_en_o | output | 1 | Current byte belongs to the CRC-covered stream |
| rx_end_o | output | 1 | One-cycle pulse when a packet closes on Idle |
| rx_null_o | output | 1 | One-cycle pulse when a prefix is followed directly by Idle |
| rx_speed_o | output | 2 | Decoded rate: 00 lowest, 01 middle, 10 highest |
| rx_speed_err_o | output | 1 | One-cycle pulse for an unrecognised rate byte |
| rx_abort_o | output | 1 | One-cycle pulse for a reserved control code during a receive |

## Verification
Every output is due exactly one rising edge after the control code and byte that cause it: the strobes, pulses and rate all come from one register stage. The bench changes the inputs 1 ns after an edge and reads the outputs 1 ns after the following edge. Each table row therefore holds the stimulus and the response to that same stimulus. There is no window in which a result could be caught early or late.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int CTL_W  = 2;
    localparam int BYTE_W = 8;
    localparam int SPD_W  = 2;
    localparam int PFX_W  = 2;   // top bits that mark a prefix byte

    typedef enum logic [CTL_W-1:0] {
        CTL_IDLE   = 2'b00,
        CTL_RSVD_A = 2'b01,
        CTL_RECV   = 2'b10,
        CTL_RSVD_B = 2'b11
    } ctl_code_e;

    typedef enum logic [SPD_W-1:0] {
        SPD_LOW  = 2'b00,
        SPD_MID  = 2'b01,
        SPD_HIGH = 2'b10
    } spd_code_e;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'b00,
        ST_PREFIX  = 2'b01,
        ST_PAYLOAD = 2'b10,
        ST_DISCARD = 2'b11
    } rx_state_e;

    typedef struct packed {
        rx_state_e         st;
        logic              first;
        logic [SPD_W-1:0]  speed;
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              start;
        logic              crc_en;
        logic              fin;
        logic              nul;
        logic              serr;
        logic              abort;
    } seq_regs_t;

endpackage

// File: rtl/rxd_ctl_decode.sv
module rxd_ctl_decode
    import rxd_pkg::*;
(
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              idle_o,
    output logic              recv_o,
    output logic              rsvd_o,
    output logic              prefix_o
);
    always_comb begin
        idle_o   = (ctl_code_e'(ctl_i) == CTL_IDLE);
        recv_o   = (ctl_code_e'(ctl_i) == CTL_RECV);
        rsvd_o   = (ctl_code_e'(ctl_i) == CTL_RSVD_A) || (ctl_code_e'(ctl_i) == CTL_RSVD_B);
        prefix_o = &byte_i[BYTE_W-1 -: PFX_W];
    end
endmodule

// File: rtl/rxd_speed_decode.sv
module rxd_speed_decode
    import rxd_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic              hit_o,
    output logic [SPD_W-1:0]  code_o
);
    localparam int NPAT = 3;
    // mask/value pairs per rate, checked in order
    localparam logic [BYTE_W-1:0] MASK [NPAT] = '{8'hC0, 8'hF0, 8'hFF};
    localparam logic [BYTE_W-1:0] VAL  [NPAT] = '{8'h00, 8'h40, 8'h50};
    localparam logic [SPD_W-1:0]  CODE [NPAT] = '{SPD_LOW, SPD_MID, SPD_HIGH};

    logic [NPAT-1:0] match;

    for (genvar g = 0; g < NPAT; g++) begin : g_pat
        assign match[g] = ((byte_i & MASK[g]) == VAL[g]);
    end

    always_comb begin
        hit_o  = |match;
        code_o = SPD_LOW;
        for (int i = NPAT-1; i >= 0; i--) begin
            if (match[i]) code_o = CODE[i];
        end
    end
endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_i,
    input  logic              recv_i,
    input  logic              rsvd_i,
    input  logic              prefix_i,
    input  logic              spd_hit_i,
    input  logic [SPD_W-1:0]  spd_code_i,
    input  logic [BYTE_W-1:0] byte_i,
    output seq_regs_t         regs_o
);
    localparam seq_regs_t SEQ_RST = '0;

    seq_regs_t regs_d, regs_q;

    always_comb begin
        regs_d        = regs_q;
        regs_d.valid  = 1'b0;
        regs_d.start  = 1'b0;
        regs_d.crc_en = 1'b0;
        regs_d.fin    = 1'b0;
        regs_d.nul    = 1'b0;
        regs_d.serr   = 1'b0;
        regs_d.abort  = 1'b0;
        unique case (regs_q.st)
            ST_WAIT: begin
                if (recv_i) regs_d.st = prefix_i ? ST_PREFIX : ST_DISCARD;
            end
            ST_PREFIX: begin
                if (idle_i) begin
                    regs_d.nul = 1'b1;
                    regs_d.st  = ST_WAIT;
                end else if (rsvd_i) begin
                    regs_d.abort = 1'b1;
                    regs_d.st    = ST_WAIT;
                end else if (!prefix_i) begin
                    if (spd_hit_i) begin
                        regs_d.speed = spd_code_i;
                        regs_d.first = 1'b1;
                        regs_d.st    = ST_PAYLOAD;
                    end else begin
                        regs_d.serr = 1'b1;
                        regs_d.st   = ST_DISCARD;
                    end
                end
            end
            ST_PAYLOAD: begin
                if (idle_i) begin
                    regs_d.fin = 1'b1;
                    regs_d.st  = ST_WAIT;
                end else if (rsvd_i) begin
                    regs_d.abort = 1'b1;
                    regs_d.st    = ST_WAIT;
                end else begin
                    regs_d.valid  = 1'b1;
                    regs_d.crc_en = 1'b1;
                    regs_d.start  = regs_q.first;
                    regs_d.first  = 1'b0;
                    regs_d.data   = byte_i;
                end
            end
            ST_DISCARD: begin
                if (idle_i) begin
                    regs_d.st = ST_WAIT;
                end else if (rsvd_i) begin
                    regs_d.abort = 1'b1;
                    regs_d.st    = ST_WAIT;
                end
            end
            default: regs_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= SEQ_RST;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/rx_pkt_decoder.sv
module rx_pkt_decoder
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTL_W-1:0]  phy_ctl_i,
    input  logic [BYTE_W-1:0] phy_byte_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              rx_start_o,
    output logic              rx_crc_en_o,
    output logic              rx_end_o,
    output logic              rx_null_o,
    output logic [SPD_W-1:0]  rx_speed_o,
    output logic              rx_speed_err_o,
    output logic              rx_abort_o
);
    logic             idle, recv, rsvd, prefix, spd_hit;
    logic [SPD_W-1:0] spd_code;
    seq_regs_t        regs;

    rxd_ctl_decode i_ctl (
        .ctl_i    (phy_ctl_i),
        .byte_i   (phy_byte_i),
        .idle_o   (idle),
        .recv_o   (recv),
        .rsvd_o   (rsvd),
        .prefix_o (prefix)
    );

    rxd_speed_decode i_spd (
        .byte_i (phy_byte_i),
        .hit_o  (spd_hit),
        .code_o (spd_code)
    );

    rxd_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_i     (idle),
        .recv_i     (recv),
        .rsvd_i     (rsvd),
        .prefix_i   (prefix),
        .spd_hit_i  (spd_hit),
        .spd_code_i (spd_code),
        .byte_i     (phy_byte_i),
        .regs_o     (regs)
    );

    assign rx_data_o      = regs.data;
    assign rx_valid_o     = regs.valid;
    assign rx_start_o     = regs.start;
    assign rx_crc_en_o    = regs.crc_en;
    assign rx_end_o       = regs.fin;
    assign rx_null_o      = regs.nul;
    assign rx_speed_o     = regs.speed;
    assign rx_speed_err_o = regs.serr;
    assign rx_abort_o     = regs.abort;
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker
    import rxd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTL_W-1:0]  phy_ctl_i,
    input logic [BYTE_W-1:0] phy_byte_i,
    input logic [BYTE_W-1:0] rx_data_o,
    input logic              rx_valid_o,
    input logic              rx_start_o,
    input logic              rx_crc_en_o,
    input logic              rx_end_o,
    input logic              rx_null_o,
    input logic [SPD_W-1:0]  rx_speed_o,
    input logic              rx_speed_err_o,
    input logic              rx_abort_o
);
    a_r4_start_is_payload: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start_o |-> (rx_valid_o && rx_crc_en_o));

    a_r5_byte_from_receive: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> ((rx_data_o == $past(phy_byte_i)) && ($past(phy_ctl_i) == 2'b10)));

    a_r6_end_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_end_o |-> (($past(phy_ctl_i) == 2'b00) && !rx_valid_o));

    a_r7_null_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_null_o |-> (($past(phy_ctl_i) == 2'b00) && !rx_valid_o));

    a_r8_error_then_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rx_speed_err_o |=> (!rx_valid_o && !rx_end_o));

    a_r9_abort_on_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort_o |-> (($past(phy_ctl_i) == 2'b01) || ($past(phy_ctl_i) == 2'b11)));

    a_r3_rate_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phy_ctl_i) != 2'b10) |-> $stable(rx_speed_o));

    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_end_o, rx_null_o, rx_speed_err_o, rx_abort_o}));
endmodule

bind rx_pkt_decoder rxd_checker i_rxd_checker (.*);

// File: tb/test_rx_pkt_decoder.sv
module test_rx_pkt_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ctl = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] rx_data;
    logic       rx_valid, rx_start, rx_crc_en, rx_end, rx_null, rx_serr, rx_abort;
    logic [1:0] rx_speed;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    rx_pkt_decoder i_rx_pkt_decoder (
        .clk(clk), .rst_n(rst_n), .phy_ctl_i(ctl), .phy_byte_i(din),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_start_o(rx_start),
        .rx_crc_en_o(rx_crc_en), .rx_end_o(rx_end), .rx_null_o(rx_null),
        .rx_speed_o(rx_speed), .rx_speed_err_o(rx_serr), .rx_abort_o(rx_abort)
    );

    // flag order: valid, start, crc, end, null, speed error, abort
    localparam logic [6:0] F0   = 7'b0000000;
    localparam logic [6:0] FST  = 7'b1110000;
    localparam logic [6:0] FDAT = 7'b1010000;
    localparam logic [6:0] FEND = 7'b0001000;
    localparam logic [6:0] FNUL = 7'b0000100;
    localparam logic [6:0] FSER = 7'b0000010;
    localparam logic [6:0] FABT = 7'b0000001;

    typedef struct packed {
        logic [1:0] ctl;
        logic [7:0] din;
        logic [6:0] flg;
        logic [1:0] spd;
        logic [7:0] dout;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VEC [NV] = '{
        // R10: waiting, non-receive codes ignored
        '{2'b00, 8'hAA, F0,   2'd0, 8'h00, 4'd10},
        '{2'b01, 8'h55, F0,   2'd0, 8'h00, 4'd10},
        '{2'b11, 8'hFF, F0,   2'd0, 8'h00, 4'd10},
        // R2 prefix, R3 middle rate, R4/R5 payload, R6 end
        '{2'b10, 8'hFF, F0,   2'd0, 8'h00, 4'd2},
        '{2'b10, 8'hC7, F0,   2'd0, 8'h00, 4'd2},
        '{2'b10, 8'h45, F0,   2'd1, 8'h00, 4'd3},
        '{2'b10, 8'h11, FST,  2'd1, 8'h11, 4'd4},
        '{2'b10, 8'h22, FDAT, 2'd1, 8'h22, 4'd5},
        '{2'b10, 8'h33, FDAT, 2'd1, 8'h33, 4'd5},
        '{2'b00, 8'h77, FEND, 2'd1, 8'h00, 4'd6},
        '{2'b00, 8'h00, F0,   2'd1, 8'h00, 4'd6},
        // R3 highest rate
        '{2'b10, 8'hFF, F0,   2'd1, 8'h00, 4'd2},
        '{2'b10, 8'h50, F0,   2'd2, 8'h00, 4'd3},
        '{2'b10, 8'hA5, FST,  2'd2, 8'hA5, 4'd4},
        '{2'b00, 8'h00, FEND, 2'd2, 8'h00, 4'd6},
        // R7 null receive
        '{2'b10, 8'hFF, F0,   2'd2, 8'h00, 4'd7},
        '{2'b00, 8'h00, FNUL, 2'd2, 8'h00, 4'd7},
        // R3 lowest rate, R4 payload byte with top bits 11
        '{2'b10, 8'hFF, F0,   2'd2, 8'h00, 4'd2},
        '{2'b10, 8'h3C, F0,   2'd0, 8'h00, 4'd3},
        '{2'b10, 8'hC3, FST,  2'd0, 8'hC3, 4'd4},
        '{2'b00, 8'h00, FEND, 2'd0, 8'h00, 4'd6},
        // R8 unknown rate bytes
        '{2'b10, 8'hFF, F0,   2'd0, 8'h00, 4'd8},
        '{2'b10, 8'h51, FSER, 2'd0, 8'h00, 4'd8},
        '{2'b10, 8'h12, F0,   2'd0, 8'h00, 4'd8},
        '{2'b10, 8'h34, F0,   2'd0, 8'h00, 4'd8},
        '{2'b00, 8'h00, F0,   2'd0, 8'h00, 4'd8},
        '{2'b10, 8'hFF, F0,   2'd0, 8'h00, 4'd8},
        '{2'b10, 8'h80, FSER, 2'd0, 8'h00, 4'd8},
        '{2'b00, 8'h00, F0,   2'd0, 8'h00, 4'd8},
        // R9 abort in payload, then R10 receive without prefix
        '{2'b10, 8'hFF, F0,   2'd0, 8'h00, 4'd9},
        '{2'b10, 8'h40, F0,   2'd1, 8'h00, 4'd9},
        '{2'b10, 8'h99, FST,  2'd1, 8'h99, 4'd9},
        '{2'b01, 8'h99, FABT, 2'd1, 8'h00, 4'd9},
        '{2'b10, 8'h55, F0,   2'd1, 8'h00, 4'd10},
        '{2'b00, 8'h00, F0,   2'd1, 8'h00, 4'd10},
        // R9 abort in prefix
        '{2'b10, 8'hFF, F0,   2'd1, 8'h00, 4'd9},
        '{2'b11, 8'hFF, FABT, 2'd1, 8'h00, 4'd9},
        '{2'b00, 8'h00, F0,   2'd1, 8'h00, 4'd9},
        // R6 end with empty payload
        '{2'b10, 8'hFF, F0,   2'd1, 8'h00, 4'd6},
        '{2'b10, 8'h00, F0,   2'd0, 8'h00, 4'd6},
        '{2'b00, 8'h00, FEND, 2'd0, 8'h00, 4'd6}
    };

    task automatic check(input int req, input logic [6:0] ef, input logic [1:0] es,
                         input logic [7:0] ed);
        logic [6:0] af;
        af = {rx_valid, rx_start, rx_crc_en, rx_end, rx_null, rx_serr, rx_abort};
        n_checks++;
        if (af !== ef || rx_speed !== es || (ef[6] && rx_data !== ed)) begin
            n_fail++;
            $display("FAIL R%0d: flags=%b speed=%0d data=%h, expected flags=%b speed=%0d data=%h",
                     req, af, rx_speed, rx_data, ef, es, ed);
        end
    endtask

    task automatic step(input logic [1:0] c, input logic [7:0] d);
        ctl = c;
        din = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1, F0, 2'd0, 8'h00);            // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].ctl, VEC[i].din);
            check(int'(VEC[i].req), VEC[i].flg, VEC[i].spd, VEC[i].dout);
        end

        // R1: reset in the middle of a packet
        step(2'b10, 8'hFF);
        step(2'b10, 8'h50);
        check(3, F0, 2'd2, 8'h00);
        step(2'b10, 8'hAB);
        check(4, FST, 2'd2, 8'hAB);
        rst_n = 1'b0;
        step(2'b10, 8'hCD);
        check(1, F0, 2'd0, 8'h00);
        rst_n = 1'b1;
        step(2'b10, 8'h22);                   // R1: no packet resumes after reset
        check(1, F0, 2'd0, 8'h00);
        step(2'b00, 8'h00);
        check(1, F0, 2'd0, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule